// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Unit

This block is the arithmetic back end of a small 16-bit signal processor. It keeps two signed 16-bit operand registers and a 32-bit accumulator. It also keeps a 16-bit status word that holds a zero flag and a negative flag. A fractional product, which is twice the signed product of the two operands, is always present combinationally on an output port.

The control logic starts one operation per cycle by raising `op_valid` with an operation kind. There are four kinds:

- A multiply-accumulate adds the current product into the accumulator and loads fresh operands in the same edge.
- A clear-and-load zeroes the accumulator, wipes the upper nibble of the status word and loads fresh operands.
- A modifier operation rewrites the accumulator in place (shift left, negate or absolute value).
- A status load writes the whole status word.

The operand values come from a pointer-read path outside this block.

Top module: `mac_unit`

## Requirements
- R1: Reset is synchronous and active high. It sets the accumulator, both operand registers and the status word to zero.
- R2: `prod` is always the signed product of `x_q` and `y_q` times two, kept to 32 bits with wraparound. For example, 0x8000 times 0x8000 gives 0x80000000.
- R3: Kind 1 (multiply-accumulate) sets the accumulator to the old accumulator plus `prod`. This is a full 32-bit add that wraps modulo 2^32 and never saturates.
- R4: Kinds 1 and 2 load `x_q` from `opnd_x` and `y_q` from `opnd_y` at the same edge. The product that is accumulated uses the operands held before that edge.
- R5: Kind 2 (clear-and-load) sets the accumulator to zero and clears status bits 15..12. Status bits 11..0 keep their values.
- R6: Kind 3 (modifier) uses `mod_code`. Code 3 shifts the accumulator left by one. Code 6 negates it. Code 7 takes its absolute value. Any other code leaves the accumulator unchanged.
- R7: The absolute value negates only a negative accumulator. 0x80000000 therefore stays 0x80000000.
- R8: After kinds 1 and 3, status bit 15 (negative) equals bit 31 of the new accumulator, and status bit 13 (zero) is set exactly when the new accumulator is zero. The other status bits are kept.
- R9: Kind 0 (status load) writes `st_wdata` into the status word. The accumulator and the operand registers are unchanged.
- R10: While `op_valid` is low, the accumulator, the operands and the status word all hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Start an operation this cycle |
| op_kind | input | 2 | 0 status load, 1 multiply-accumulate, 2 clear-and-load, 3 modifier |
| mod_code | input | 3 | Modifier select: 3 shift left, 6 negate, 7 absolute value |
| opnd_x | input | 16 | New X operand |
| opnd_y | input | 16 | New Y operand |
| st_wdata | input | 16 | Status value for a status load |
| x_q | output | 16 | X operand register |
| y_q | output | 16 | Y operand register |
| prod | output | 32 | Doubled signed product of X and Y |
| acc | output | 32 | Accumulator |
| status | output | 16 | Status word: bit 15 negative, bit 13 zero |

## Verification
Every piece of state drives a port directly, so a wrong accumulator, operand or flag value shows up one cycle after the operation that caused it. A product taken from the freshly loaded operands instead of the held ones gives a wrong accumulator on the very next multiply-accumulate. A missing sign extension or a missing doubling is exposed by the most negative operands and by boundary sums that wrap past bit 31. A bad flag update is visible in `status` at once, and a bad nibble mask is visible after the first clear-and-load that follows a status load with all bits set.

// File: rtl/mac_pkg.sv
package mac_pkg;
    typedef enum logic [1:0] {
        OPK_STLD  = 2'd0,
        OPK_MAC   = 2'd1,
        OPK_CLRLD = 2'd2,
        OPK_MOD   = 2'd3
    } op_kind_e;

    typedef enum logic [2:0] {
        MOD_SHL = 3'd3,
        MOD_NEG = 3'd6,
        MOD_ABS = 3'd7
    } mod_code_e;

    localparam int ST_W     = 16;
    localparam int ST_NEG   = 15;
    localparam int ST_ZERO  = 13;
    localparam int ST_NIB_L = 12;

    typedef struct packed {
        logic [ST_W-1:0] value;
        logic            flags_upd;
    } st_ctl_t;
endpackage

// File: rtl/mac_mult.sv
module mac_mult #(
    parameter int DW = 16,
    localparam int PW = 2*DW
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [PW-1:0] p
);
    logic signed [PW-1:0] full;

    always_comb begin
        full = PW'($signed(a)) * PW'($signed(b));
        p    = full << 1;
    end
endmodule

// File: rtl/mac_acc_alu.sv
module mac_acc_alu
    import mac_pkg::*;
#(
    parameter int AW = 32
) (
    input  op_kind_e        kind,
    input  logic [2:0]      mod_code,
    input  logic [AW-1:0]   acc_cur,
    input  logic [AW-1:0]   prod,
    output logic [AW-1:0]   acc_nxt,
    output logic            flags_upd
);
    logic [AW-1:0] mod_res;

    always_comb begin
        unique case (mod_code)
            MOD_SHL: mod_res = acc_cur << 1;
            MOD_NEG: mod_res = AW'(0) - acc_cur;
            MOD_ABS: mod_res = acc_cur[AW-1] ? AW'(0) - acc_cur : acc_cur;
            default: mod_res = acc_cur;
        endcase
    end

    always_comb begin
        acc_nxt   = acc_cur;
        flags_upd = 1'b0;
        unique case (kind)
            OPK_MAC: begin
                acc_nxt   = acc_cur + prod;
                flags_upd = 1'b1;
            end
            OPK_CLRLD: acc_nxt = '0;
            OPK_MOD: begin
                acc_nxt   = mod_res;
                flags_upd = 1'b1;
            end
            default: acc_nxt = acc_cur;
        endcase
    end
endmodule

// File: rtl/mac_status_upd.sv
module mac_status_upd
    import mac_pkg::*;
#(
    parameter int AW = 32
) (
    input  op_kind_e          kind,
    input  logic              flags_upd,
    input  logic [AW-1:0]     acc_nxt,
    input  logic [ST_W-1:0]   st_cur,
    input  logic [ST_W-1:0]   st_wdata,
    output st_ctl_t           st_nxt
);
    always_comb begin
        st_nxt.value     = st_cur;
        st_nxt.flags_upd = flags_upd;
        if (kind == OPK_STLD) begin
            st_nxt.value = st_wdata;
        end else if (kind == OPK_CLRLD) begin
            st_nxt.value[ST_W-1:ST_NIB_L] = '0;
        end else if (flags_upd) begin
            st_nxt.value[ST_NEG]  = acc_nxt[AW-1];
            st_nxt.value[ST_ZERO] = (acc_nxt == '0);
        end
    end
endmodule

// File: rtl/mac_unit.sv
module mac_unit
    import mac_pkg::*;
#(
    parameter int DW = 16,
    localparam int AW = 2*DW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            op_valid,
    input  logic [1:0]      op_kind,
    input  logic [2:0]      mod_code,
    input  logic [DW-1:0]   opnd_x,
    input  logic [DW-1:0]   opnd_y,
    input  logic [ST_W-1:0] st_wdata,
    output logic [DW-1:0]   x_q,
    output logic [DW-1:0]   y_q,
    output logic [AW-1:0]   prod,
    output logic [AW-1:0]   acc,
    output logic [ST_W-1:0] status
);
    op_kind_e      kind;
    logic [AW-1:0] acc_nxt;
    logic          flags_upd;
    st_ctl_t       st_nxt;
    logic          load_ops;

    assign kind     = op_kind_e'(op_kind);
    assign load_ops = op_valid && (kind == OPK_MAC || kind == OPK_CLRLD);

    mac_mult #(.DW(DW)) u_mult (
        .a (x_q),
        .b (y_q),
        .p (prod)
    );

    mac_acc_alu #(.AW(AW)) u_alu (
        .kind      (kind),
        .mod_code  (mod_code),
        .acc_cur   (acc),
        .prod      (prod),
        .acc_nxt   (acc_nxt),
        .flags_upd (flags_upd)
    );

    mac_status_upd #(.AW(AW)) u_st (
        .kind      (kind),
        .flags_upd (flags_upd),
        .acc_nxt   (acc_nxt),
        .st_cur    (status),
        .st_wdata  (st_wdata),
        .st_nxt    (st_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc    <= '0;
            x_q    <= '0;
            y_q    <= '0;
            status <= '0;
        end else if (op_valid) begin
            acc    <= acc_nxt;
            status <= st_nxt.value;
            if (load_ops) begin
                x_q <= opnd_x;
                y_q <= opnd_y;
            end
        end
    end

    assert_mac_sum_R3: assert property (@(posedge clk) disable iff (rst)
        (op_valid && kind == OPK_MAC) |=> acc == $past(acc) + $past(prod));

    assert_operand_load_R4: assert property (@(posedge clk) disable iff (rst)
        load_ops |=> (x_q == $past(opnd_x) && y_q == $past(opnd_y)));

    assert_clear_mask_R5: assert property (@(posedge clk) disable iff (rst)
        (op_valid && kind == OPK_CLRLD) |=>
            (acc == '0 && status[ST_W-1:ST_NIB_L] == '0 &&
             status[ST_NIB_L-1:0] == $past(status[ST_NIB_L-1:0])));

    assert_flags_R8: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (kind == OPK_MAC || kind == OPK_MOD)) |=>
            (status[ST_NEG] == acc[AW-1] && status[ST_ZERO] == (acc == '0)));

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> ($stable(acc) && $stable(x_q) && $stable(y_q) && $stable(status)));
endmodule

// File: tb/tb_mac_unit.sv
module tb_mac_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [1:0]  op_kind;
    logic [2:0]  mod_code;
    logic [15:0] opnd_x, opnd_y, st_wdata;
    logic [15:0] x_q, y_q, status;
    logic [31:0] prod, acc;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [15:0] mx, my, ms;
    logic [31:0] ma;

    mac_unit dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind),
        .mod_code(mod_code), .opnd_x(opnd_x), .opnd_y(opnd_y),
        .st_wdata(st_wdata), .x_q(x_q), .y_q(y_q), .prod(prod),
        .acc(acc), .status(status)
    );

    always #2 clk = ~clk;

    typedef struct packed {
        logic [1:0]  k;
        logic [2:0]  m;
        logic [15:0] ox;
        logic [15:0] oy;
        logic [15:0] sw;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 3'd0, 16'h0000, 16'h0000, 16'hF0A5},
        '{2'd2, 3'd0, 16'h0003, 16'h0005, 16'h0000},
        '{2'd1, 3'd0, 16'hFFFE, 16'h0007, 16'h0000},
        '{2'd1, 3'd0, 16'h8000, 16'h8000, 16'h0000},
        '{2'd1, 3'd0, 16'h0000, 16'h0000, 16'h0000},
        '{2'd3, 3'd7, 16'h1111, 16'h2222, 16'h0000},
        '{2'd3, 3'd6, 16'h0000, 16'h0000, 16'h0000},
        '{2'd3, 3'd3, 16'h0000, 16'h0000, 16'h0000},
        '{2'd3, 3'd1, 16'h0000, 16'h0000, 16'h0000},
        '{2'd2, 3'd0, 16'h1234, 16'h0000, 16'h0000},
        '{2'd3, 3'd6, 16'h0000, 16'h0000, 16'h0000},
        '{2'd0, 3'd0, 16'h0000, 16'h0000, 16'hFFFF},
        '{2'd1, 3'd0, 16'h7FFF, 16'h7FFF, 16'h0000},
        '{2'd1, 3'd0, 16'h0000, 16'h0000, 16'h0000}
    };

    function automatic logic [31:0] ref_prod(logic [15:0] a, logic [15:0] b);
        longint pa, pb;
        pa = longint'($signed(a));
        pb = longint'($signed(b));
        return 32'(pa * pb * 2);
    endfunction

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic model_step(vec_t v);
        logic [31:0] p;
        logic        fl;
        p  = ref_prod(mx, my);
        fl = 1'b0;
        case (v.k)
            2'd0: ms = v.sw;
            2'd1: begin ma = ma + p; fl = 1'b1; mx = v.ox; my = v.oy; end
            2'd2: begin ma = 32'd0; ms = ms & 16'h0FFF; mx = v.ox; my = v.oy; end
            default: begin
                fl = 1'b1;
                if (v.m == 3'd3) ma = {ma[30:0], 1'b0};
                else if (v.m == 3'd6) ma = ~ma + 32'd1;
                else if (v.m == 3'd7 && ma[31]) ma = ~ma + 32'd1;
            end
        endcase
        if (fl) begin
            ms[15] = ma[31];
            ms[13] = (ma == 32'd0);
        end
    endtask

    task automatic apply(vec_t v);
        op_valid = 1'b1;
        op_kind  = v.k;
        mod_code = v.m;
        opnd_x   = v.ox;
        opnd_y   = v.oy;
        st_wdata = v.sw;
        @(negedge clk);
        op_valid = 1'b0;
        model_step(v);
    endtask

    task automatic check_all(string tag);
        chk({tag, " R3/R6/R7 acc"}, acc, ma);
        chk({tag, " R4 x"}, {16'd0, x_q}, {16'd0, mx});
        chk({tag, " R4 y"}, {16'd0, y_q}, {16'd0, my});
        chk({tag, " R5/R8/R9 status"}, {16'd0, status}, {16'd0, ms});
        chk({tag, " R2 prod"}, prod, ref_prod(mx, my));
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; op_valid = 1'b0; op_kind = 2'd0; mod_code = 3'd0;
        opnd_x = 16'd0; opnd_y = 16'd0; st_wdata = 16'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        mx = 16'd0; my = 16'd0; ms = 16'd0; ma = 32'd0;
        // R1 reset state
        chk("R1 acc", acc, 32'd0);
        chk("R1 xy", {x_q, y_q}, 32'd0);
        chk("R1 status", {16'd0, status}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            check_all($sformatf("vec%0d", i));
        end

        // R10: op_valid low holds everything despite active inputs
        op_kind = 2'd2; opnd_x = 16'hBEEF; opnd_y = 16'hCAFE; st_wdata = 16'h5555;
        repeat (2) @(negedge clk);
        check_all("R10 hold");

        // R7: absolute value of the most negative accumulator
        apply('{2'd2, 3'd0, 16'h8000, 16'h8000, 16'h0000});
        apply('{2'd1, 3'd0, 16'h0000, 16'h0000, 16'h0000});
        chk("R7 setup", acc, 32'h8000_0000);
        apply('{2'd3, 3'd7, 16'h0000, 16'h0000, 16'h0000});
        chk("R7 abs min", acc, 32'h8000_0000);
        chk("R8 neg flag", {31'd0, status[15]}, 32'd1);
        apply('{2'd3, 3'd3, 16'h0000, 16'h0000, 16'h0000});
        chk("R6 shl wrap", acc, 32'd0);
        chk("R8 zero flag", {31'd0, status[13]}, 32'd1);

        // R1: reset from a loaded state
        apply('{2'd0, 3'd0, 16'h0000, 16'h0000, 16'h7777});
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 re-reset acc", acc, 32'd0);
        chk("R1 re-reset xy", {x_q, y_q}, 32'd0);
        chk("R1 re-reset status", {16'd0, status}, 32'd0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule